// File: doc/BRIEF.md
# Banked Operand Address Generator

This block turns an addressing-mode selection, the operand bytes of an instruction and a snapshot of the processor's register file (direct-page base, two index registers, stack pointer, data bank) into the 24-bit address of a data operand. The register file is 16 bits wide and the address space is 24 bits. Some modes build the address in one step. Others first need a pointer from bank 0. For those modes the block tells an outside sequencer where to read the pointer and how many bytes to read, waits for the bytes, and then finishes the address.

A caller pulses `start` with every input valid. A mode that needs no pointer gives its address on the next cycle. An indirect mode raises `ptr_req` on the next cycle and keeps `ptr_addr` and `ptr_len` steady until `ptr_valid`. The finished address appears one cycle after the pointer is accepted. The block also reports whether the access takes an extra cycle because the direct-page base does not start on a page boundary. It takes no new request while it waits for a pointer.

Top module: `eagen_top`

## Requirements
- R1: After reset, `ea_valid`, `ptr_req` and `extra_cyc` are 0 and `ea` is 0.
- R2: Modes 0 (page), 1 (page + X), 2 (page + Y) and 11 (stack + offset) add an unsigned 8-bit offset (`opnd[7:0]`) and, where the mode names one, an index to the page base (`reg_d`), or to `reg_s` for mode 11. The sum wraps at 16 bits and sits in bank 0. `ea_valid` pulses one cycle after the accepted `start`.
- R3: Mode 3 forms `{reg_db, opnd[15:0]}`. Modes 4 and 5 add X or Y to `opnd[15:0]`, wrap at 16 bits and use `reg_db` as the bank. The result is valid one cycle after `start`.
- R4: Mode 6 uses `opnd[23:0]` as it is. Mode 7 adds X to `opnd[23:0]` with the carry running through all 24 bits.
- R5: Modes 8, 9, 10, 12, 13 and 14 raise `ptr_req` one cycle after `start`. The pointer address is in bank 0 and wraps at 16 bits: `reg_d + opnd[7:0]` in general, `+ X` as well for mode 10, and `reg_s + opnd[7:0]` for mode 12. `ptr_len` is 3 for modes 9 and 14 and 2 otherwise. Request, address and length hold until `ptr_valid`.
- R6: The final address appears with an `ea_valid` pulse on the cycle after the cycle in which `ptr_req` and `ptr_valid` are both high. `ptr_req` falls on that same edge.
- R7: In 2-byte pointer modes the final address takes `ptr_data[15:0]` with `reg_db` above it and ignores `ptr_data[23:16]`. Modes 8 and 12 then add Y across all 24 bits, so a carry can enter the bank byte. Modes 10 and 13 add nothing.
- R8: Mode 9 adds Y to the 24-bit pointer `ptr_data` across all 24 bits. Mode 14 uses `ptr_data` as it is.
- R9: `extra_cyc` is updated on each accepted `start` and holds until the next one. It is 1 when the mode is one of 0, 1, 2, 8, 9, 10, 13 or 14 and `reg_d[7:0]` is nonzero.
- R10: When `idx8` or `emu` is 1, only the low byte of X and Y is used and the upper byte counts as zero.
- R11: A `start` that arrives while `ptr_req` is high is ignored: it produces no extra `ea_valid` and does not change `extra_cyc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing-mode code |
| opnd | input | 24 | Operand bytes, first byte in [7:0] |
| reg_d | input | 16 | Direct-page base |
| reg_x | input | 16 | X index |
| reg_y | input | 16 | Y index |
| reg_s | input | 16 | Stack pointer |
| reg_db | input | 8 | Data bank |
| emu | input | 1 | Emulation flag (forces 8-bit indexes) |
| idx8 | input | 1 | 8-bit index flag |
| ptr_req | output | 1 | Pointer fetch request |
| ptr_addr | output | 24 | Address of the pointer to fetch |
| ptr_len | output | 2 | Pointer byte count (2 or 3) |
| ptr_valid | input | 1 | Pointer bytes present on ptr_data |
| ptr_data | input | 24 | Fetched pointer, little-endian assembled |
| ea_valid | output | 1 | One-cycle pulse: ea holds a new address |
| ea | output | 24 | Effective address |
| extra_cyc | output | 1 | Page-misaligned direct base penalty |

## Verification
Completing a pointer fetch and accepting a new request can fall on the same cycle. The bench provokes this by raising `start` with a page mode and a misaligned base in the very cycle `ptr_valid` arrives. It then checks three things: the address belongs to the pending indirect request, no second `ea_valid` pulse follows, and `extra_cyc` keeps the value from the earlier request. Random runs mix every mode with aligned and misaligned bases, narrow and wide indexes, and pointer latencies of zero to two cycles. Directed cases push carries across bank and 16-bit boundaries.

// File: rtl/eagen_pkg.sv
package eagen_pkg;
  localparam int EA_W = 24;
  localparam int RG_W = 16;
  localparam int BK_W = EA_W - RG_W;
  localparam int OF_W = 8;

  typedef enum logic [3:0] {
    AM_PAGE      = 4'd0,
    AM_PAGE_X    = 4'd1,
    AM_PAGE_Y    = 4'd2,
    AM_ABS       = 4'd3,
    AM_ABS_X     = 4'd4,
    AM_ABS_Y     = 4'd5,
    AM_FAR       = 4'd6,
    AM_FAR_X     = 4'd7,
    AM_PIND_Y    = 4'd8,
    AM_PFAR_Y    = 4'd9,
    AM_PX_IND    = 4'd10,
    AM_STK       = 4'd11,
    AM_STK_IND_Y = 4'd12,
    AM_PIND      = 4'd13,
    AM_PFAR      = 4'd14,
    AM_SPARE     = 4'd15
  } amode_t;

  function automatic logic needs_ptr(amode_t m);
    return (m == AM_PIND_Y) || (m == AM_PFAR_Y) || (m == AM_PX_IND) ||
           (m == AM_STK_IND_Y) || (m == AM_PIND) || (m == AM_PFAR);
  endfunction

  function automatic logic page_based(amode_t m);
    return (m == AM_PAGE) || (m == AM_PAGE_X) || (m == AM_PAGE_Y) ||
           (m == AM_PIND_Y) || (m == AM_PFAR_Y) || (m == AM_PX_IND) ||
           (m == AM_PIND) || (m == AM_PFAR);
  endfunction

  function automatic logic [1:0] ptr_bytes(amode_t m);
    return ((m == AM_PFAR_Y) || (m == AM_PFAR)) ? 2'd3 : 2'd2;
  endfunction

  // base + offset + index, wrapped to 16 bits, placed in bank 0
  function automatic logic [EA_W-1:0] bank0_sum(logic [RG_W-1:0] base,
                                                logic [OF_W-1:0] off,
                                                logic [RG_W-1:0] idx);
    logic [RG_W-1:0] s;
    s = base + {{(RG_W-OF_W){1'b0}}, off} + idx;
    return {{BK_W{1'b0}}, s};
  endfunction

  // bank byte over a 16-bit word that wraps on its own
  function automatic logic [EA_W-1:0] bank_word(logic [BK_W-1:0] bank,
                                                logic [RG_W-1:0] lo,
                                                logic [RG_W-1:0] idx);
    logic [RG_W-1:0] s;
    s = lo + idx;
    return {bank, s};
  endfunction

  // index added over the full address width, carry into the bank
  function automatic logic [EA_W-1:0] carry_add(logic [EA_W-1:0] base,
                                                logic [RG_W-1:0] idx);
    return base + {{BK_W{1'b0}}, idx};
  endfunction
endpackage

// File: rtl/eagen_index_sel.sv
module eagen_index_sel #(
  parameter int REG_W = eagen_pkg::RG_W
) (
  input  logic             narrow,
  input  logic [REG_W-1:0] x_in,
  input  logic [REG_W-1:0] y_in,
  output logic [REG_W-1:0] x_eff,
  output logic [REG_W-1:0] y_eff
);
  localparam int LO_W = REG_W / 2;
  localparam int N_IX = 2;

  logic [N_IX-1:0][REG_W-1:0] raw;
  logic [N_IX-1:0][REG_W-1:0] cut;

  assign raw = {y_in, x_in};

  for (genvar g = 0; g < N_IX; g++) begin : g_ix
    assign cut[g] = narrow ? {{(REG_W-LO_W){1'b0}}, raw[g][LO_W-1:0]} : raw[g];
  end

  assign x_eff = cut[0];
  assign y_eff = cut[1];
endmodule

// File: rtl/eagen_addr_form.sv
module eagen_addr_form
  import eagen_pkg::*;
#(
  parameter int ADDR_W = eagen_pkg::EA_W,
  parameter int REG_W  = eagen_pkg::RG_W
) (
  input  amode_t            mode,
  input  logic [ADDR_W-1:0] opnd,
  input  logic [REG_W-1:0]  d,
  input  logic [REG_W-1:0]  s,
  input  logic [ADDR_W-REG_W-1:0] db,
  input  logic [REG_W-1:0]  xe,
  input  logic [REG_W-1:0]  ye,
  output logic [ADDR_W-1:0] direct_ea,
  output logic [ADDR_W-1:0] ptr_at,
  output logic [1:0]        ptr_n,
  output logic              ind,
  output logic              pen
);
  localparam int LOW_B = 8;

  logic [LOW_B-1:0]  off;
  logic [REG_W-1:0]  word;
  logic [ADDR_W-1:0] pg, pgx, pgy, stk;

  assign off  = opnd[LOW_B-1:0];
  assign word = opnd[REG_W-1:0];
  assign pg   = bank0_sum(d, off, '0);
  assign pgx  = bank0_sum(d, off, xe);
  assign pgy  = bank0_sum(d, off, ye);
  assign stk  = bank0_sum(s, off, '0);

  always_comb begin
    case (mode)
      AM_PAGE:   direct_ea = pg;
      AM_PAGE_X: direct_ea = pgx;
      AM_PAGE_Y: direct_ea = pgy;
      AM_ABS:    direct_ea = bank_word(db, word, '0);
      AM_ABS_X:  direct_ea = bank_word(db, word, xe);
      AM_ABS_Y:  direct_ea = bank_word(db, word, ye);
      AM_FAR_X:  direct_ea = carry_add(opnd, xe);
      AM_STK:    direct_ea = stk;
      default:   direct_ea = opnd;
    endcase
  end

  always_comb begin
    case (mode)
      AM_PX_IND:    ptr_at = pgx;
      AM_STK_IND_Y: ptr_at = stk;
      default:      ptr_at = pg;
    endcase
  end

  assign ptr_n = ptr_bytes(mode);
  assign ind   = needs_ptr(mode);
  assign pen   = page_based(mode) && (d[LOW_B-1:0] != '0);
endmodule

// File: rtl/eagen_resolve.sv
module eagen_resolve
  import eagen_pkg::*;
#(
  parameter int ADDR_W = eagen_pkg::EA_W,
  parameter int REG_W  = eagen_pkg::RG_W
) (
  input  amode_t                  mode_q,
  input  logic [ADDR_W-REG_W-1:0] db_q,
  input  logic [REG_W-1:0]        ye_q,
  input  logic [ADDR_W-1:0]       ptr_data,
  output logic [ADDR_W-1:0]       final_ea
);
  logic [ADDR_W-1:0] short_base;

  assign short_base = {db_q, ptr_data[REG_W-1:0]};

  always_comb begin
    case (mode_q)
      AM_PIND_Y, AM_STK_IND_Y: final_ea = carry_add(short_base, ye_q);
      AM_PFAR_Y:               final_ea = carry_add(ptr_data, ye_q);
      AM_PX_IND, AM_PIND:      final_ea = short_base;
      default:                 final_ea = ptr_data;
    endcase
  end
endmodule

// File: rtl/eagen_seq.sv
module eagen_seq
  import eagen_pkg::*;
#(
  parameter int ADDR_W = eagen_pkg::EA_W,
  parameter int REG_W  = eagen_pkg::RG_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  amode_t                  mode_in,
  input  logic [ADDR_W-REG_W-1:0] db_in,
  input  logic [REG_W-1:0]        ye_in,
  input  logic [ADDR_W-1:0]       direct_ea,
  input  logic [ADDR_W-1:0]       ptr_at,
  input  logic [1:0]              ptr_n,
  input  logic                    ind,
  input  logic                    pen,
  input  logic                    ptr_valid,
  input  logic [ADDR_W-1:0]       final_ea,
  output logic                    accept,
  output logic                    ptr_done,
  output amode_t                  mode_q,
  output logic [ADDR_W-REG_W-1:0] db_q,
  output logic [REG_W-1:0]        ye_q,
  output logic                    ptr_req,
  output logic [ADDR_W-1:0]       ptr_addr,
  output logic [1:0]              ptr_len,
  output logic                    ea_valid,
  output logic [ADDR_W-1:0]       ea,
  output logic                    extra_cyc
);
  typedef enum logic {ST_IDLE, ST_FETCH} st_t;
  st_t st;

  assign accept   = start && (st == ST_IDLE);
  assign ptr_done = (st == ST_FETCH) && ptr_valid;
  assign ptr_req  = (st == ST_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ea        <= '0;
      ea_valid  <= 1'b0;
      ptr_addr  <= '0;
      ptr_len   <= 2'd0;
      extra_cyc <= 1'b0;
      mode_q    <= AM_PAGE;
      db_q      <= '0;
      ye_q      <= '0;
    end else begin
      ea_valid <= 1'b0;
      if (accept) begin
        extra_cyc <= pen;
        mode_q    <= mode_in;
        db_q      <= db_in;
        ye_q      <= ye_in;
        if (ind) begin
          st       <= ST_FETCH;
          ptr_addr <= ptr_at;
          ptr_len  <= ptr_n;
        end else begin
          ea       <= direct_ea;
          ea_valid <= 1'b1;
        end
      end else if (ptr_done) begin
        ea       <= final_ea;
        ea_valid <= 1'b1;
        st       <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/eagen_top.sv
module eagen_top
  import eagen_pkg::*;
#(
  parameter int ADDR_W = eagen_pkg::EA_W,
  parameter int REG_W  = eagen_pkg::RG_W,
  localparam int BNK_W = ADDR_W - REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] opnd,
  input  logic [REG_W-1:0]  reg_d,
  input  logic [REG_W-1:0]  reg_x,
  input  logic [REG_W-1:0]  reg_y,
  input  logic [REG_W-1:0]  reg_s,
  input  logic [BNK_W-1:0]  reg_db,
  input  logic              emu,
  input  logic              idx8,
  output logic              ptr_req,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic [1:0]        ptr_len,
  input  logic              ptr_valid,
  input  logic [ADDR_W-1:0] ptr_data,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea,
  output logic              extra_cyc
);
  amode_t            mode_t_in, mode_q;
  logic [REG_W-1:0]  xe, ye, ye_q;
  logic [BNK_W-1:0]  db_q;
  logic [ADDR_W-1:0] direct_ea, ptr_at, final_ea;
  logic [1:0]        ptr_n;
  logic              need_ptr, dp_pen;
  logic              accept_start, ptr_done;

  assign mode_t_in = amode_t'(mode);

  eagen_index_sel #(.REG_W(REG_W)) u_ix (
    .narrow(idx8 | emu), .x_in(reg_x), .y_in(reg_y),
    .x_eff(xe), .y_eff(ye)
  );

  eagen_addr_form #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_form (
    .mode(mode_t_in), .opnd(opnd), .d(reg_d), .s(reg_s), .db(reg_db),
    .xe(xe), .ye(ye), .direct_ea(direct_ea), .ptr_at(ptr_at),
    .ptr_n(ptr_n), .ind(need_ptr), .pen(dp_pen)
  );

  eagen_resolve #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_res (
    .mode_q(mode_q), .db_q(db_q), .ye_q(ye_q), .ptr_data(ptr_data),
    .final_ea(final_ea)
  );

  eagen_seq #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_t_in),
    .db_in(reg_db), .ye_in(ye), .direct_ea(direct_ea), .ptr_at(ptr_at),
    .ptr_n(ptr_n), .ind(need_ptr), .pen(dp_pen), .ptr_valid(ptr_valid),
    .final_ea(final_ea), .accept(accept_start), .ptr_done(ptr_done),
    .mode_q(mode_q), .db_q(db_q), .ye_q(ye_q), .ptr_req(ptr_req),
    .ptr_addr(ptr_addr), .ptr_len(ptr_len), .ea_valid(ea_valid),
    .ea(ea), .extra_cyc(extra_cyc)
  );
endmodule

// File: rtl/eagen_chk.sv
module eagen_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ptr_valid,
  input logic              ptr_req,
  input logic [ADDR_W-1:0] ptr_addr,
  input logic [1:0]        ptr_len,
  input logic              ea_valid,
  input logic              extra_cyc,
  input logic              accept_start,
  input logic              need_ptr,
  input logic              dp_pen
);
  localparam int REG_W = 16;

  p_direct_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start && !need_ptr |=> ea_valid && !ptr_req);

  p_req_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start && need_ptr |=> ptr_req && !ea_valid);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req && !ptr_valid |=> ptr_req && $stable(ptr_addr) && $stable(ptr_len));

  p_ptr_bank0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req |-> (ptr_addr[ADDR_W-1:REG_W] == '0) && (ptr_len == 2'd2 || ptr_len == 2'd3));

  p_ea_after_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req && ptr_valid |=> ea_valid && !ptr_req);

  p_pen_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> extra_cyc == $past(dp_pen));

  p_pen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_start |=> $stable(extra_cyc));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req && start |-> !accept_start);

  p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ea_valid && ptr_req));
endmodule

bind eagen_top eagen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ptr_valid(ptr_valid),
  .ptr_req(ptr_req), .ptr_addr(ptr_addr), .ptr_len(ptr_len),
  .ea_valid(ea_valid), .extra_cyc(extra_cyc), .accept_start(accept_start),
  .need_ptr(need_ptr), .dp_pen(dp_pen)
);

// File: tb/sim_eagen_top.sv
module sim_eagen_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, emu, idx8, ptr_valid;
  logic [3:0]  mode;
  logic [23:0] opnd, ptr_data;
  logic [15:0] reg_d, reg_x, reg_y, reg_s;
  logic [7:0]  reg_db;
  logic        ptr_req, ea_valid, extra_cyc;
  logic [23:0] ptr_addr, ea;
  logic [1:0]  ptr_len;

  logic [7:0]  mem [0:63];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  eagen_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opnd(opnd),
    .reg_d(reg_d), .reg_x(reg_x), .reg_y(reg_y), .reg_s(reg_s),
    .reg_db(reg_db), .emu(emu), .idx8(idx8), .ptr_req(ptr_req),
    .ptr_addr(ptr_addr), .ptr_len(ptr_len), .ptr_valid(ptr_valid),
    .ptr_data(ptr_data), .ea_valid(ea_valid), .ea(ea), .extra_cyc(extra_cyc)
  );

  task automatic chk(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_ind(int m);
    return m == 8 || m == 9 || m == 10 || m == 12 || m == 13 || m == 14;
  endfunction

  function automatic bit is_pg(int m);
    return m <= 2 || m == 8 || m == 9 || m == 10 || m == 13 || m == 14;
  endfunction

  function automatic int nbytes(int m);
    return (m == 9 || m == 14) ? 3 : 2;
  endfunction

  function automatic string tag_of(int m);
    if (m <= 2 || m == 11) return "R2";
    if (m <= 5) return "R3";
    if (m <= 7) return "R4";
    if (m == 9 || m == 14) return "R8";
    return "R7";
  endfunction

  function automatic logic [15:0] wrap16(longint v);
    return v[15:0];
  endfunction

  function automatic logic [23:0] want_ptr_at(int m, logic [23:0] op,
      logic [15:0] d, logic [15:0] xi, logic [15:0] s);
    if (m == 10) return {8'h00, wrap16(longint'(d) + op[7:0] + xi)};
    if (m == 12) return {8'h00, wrap16(longint'(s) + op[7:0])};
    return {8'h00, wrap16(longint'(d) + op[7:0])};
  endfunction

  function automatic logic [23:0] want_direct(int m, logic [23:0] op,
      logic [15:0] d, logic [15:0] xi, logic [15:0] yi, logic [15:0] s,
      logic [7:0] db);
    longint t;
    case (m)
      0:  return {8'h00, wrap16(longint'(d) + op[7:0])};
      1:  return {8'h00, wrap16(longint'(d) + op[7:0] + xi)};
      2:  return {8'h00, wrap16(longint'(d) + op[7:0] + yi)};
      3:  return {db, op[15:0]};
      4:  return {db, wrap16(longint'(op[15:0]) + xi)};
      5:  return {db, wrap16(longint'(op[15:0]) + yi)};
      7:  begin t = longint'(op) + xi; return t[23:0]; end
      11: return {8'h00, wrap16(longint'(s) + op[7:0])};
      default: return op;
    endcase
  endfunction

  function automatic logic [23:0] want_final(int m, logic [23:0] p,
      logic [7:0] db, logic [15:0] yi);
    longint b;
    b = (nbytes(m) == 3) ? longint'(p) : longint'({db, p[15:0]});
    if (m == 8 || m == 9 || m == 12) b = b + yi;
    return b[23:0];
  endfunction

  function automatic logic [23:0] fetch(logic [23:0] pa);
    logic [23:0] r;
    for (int i = 0; i < 3; i++) begin
      logic [15:0] a;
      a = pa[15:0] + 16'(i);
      r[i*8 +: 8] = mem[a[5:0]];
    end
    return r;
  endfunction

  task automatic run_op(int m, logic [23:0] op, logic [15:0] d,
      logic [15:0] x, logic [15:0] y, logic [15:0] s, logic [7:0] db,
      bit n8, bit em, int wait_n, bit clash, string note);
    logic [15:0] xi, yi;
    logic [23:0] pa, pd, exp;
    bit pen;
    string t;
    t   = $sformatf("%s %s mode=%0d", tag_of(m), note, m);
    xi  = (n8 | em) ? {8'h00, x[7:0]} : x;
    yi  = (n8 | em) ? {8'h00, y[7:0]} : y;
    pen = is_pg(m) && (d[7:0] != 8'h00);
    @(negedge clk);
    mode = 4'(m); opnd = op; reg_d = d; reg_x = x; reg_y = y; reg_s = s;
    reg_db = db; idx8 = n8; emu = em; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(extra_cyc == pen, "R9 extra cycle flag", 24'(extra_cyc), 24'(pen));
    if (is_ind(m)) begin
      pa = want_ptr_at(m, op, d, xi, s);
      chk(ptr_req == 1'b1, "R5 request raised", 24'(ptr_req), 24'd1);
      chk(ptr_addr == pa, "R5 pointer address", ptr_addr, pa);
      chk(ptr_len == 2'(nbytes(m)), "R5 pointer length", 24'(ptr_len), 24'(nbytes(m)));
      for (int k = 0; k < wait_n; k++) begin
        @(negedge clk);
        chk(ptr_req == 1'b1 && ptr_addr == pa, "R5 request held", ptr_addr, pa);
      end
      pd = fetch(pa);
      ptr_data = pd; ptr_valid = 1'b1;
      if (clash) begin
        // R11: new page-mode request with misaligned base during completion
        start = 1'b1; mode = 4'd0; reg_d = 16'h0101;
      end
      @(negedge clk);
      ptr_valid = 1'b0; start = 1'b0;
      exp = want_final(m, pd, db, yi);
      chk(ea_valid == 1'b1, "R6 valid after pointer", 24'(ea_valid), 24'd1);
      chk(ptr_req == 1'b0, "R6 request dropped", 24'(ptr_req), 24'd0);
      chk(ea == exp, t, ea, exp);
      if (clash) begin
        @(negedge clk);
        chk(ea_valid == 1'b0, "R11 busy start ignored", 24'(ea_valid), 24'd0);
        chk(extra_cyc == pen, "R11 flag unchanged", 24'(extra_cyc), 24'(pen));
      end
    end else begin
      exp = want_direct(m, op, d, xi, yi, s, db);
      chk(ea_valid == 1'b1, "R2 valid next cycle", 24'(ea_valid), 24'd1);
      chk(ptr_req == 1'b0, "R2 no request", 24'(ptr_req), 24'd0);
      chk(ea == exp, t, ea, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    rst_n = 1'b0; start = 1'b0; ptr_valid = 1'b0; mode = 4'd0; opnd = '0;
    reg_d = '0; reg_x = '0; reg_y = '0; reg_s = '0; reg_db = '0;
    emu = 1'b0; idx8 = 1'b0; ptr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ea_valid == 1'b0, "R1 valid low", 24'(ea_valid), 24'd0);
    chk(ptr_req == 1'b0, "R1 request low", 24'(ptr_req), 24'd0);
    chk(extra_cyc == 1'b0, "R1 flag low", 24'(extra_cyc), 24'd0);
    chk(ea == 24'd0, "R1 address zero", ea, 24'd0);

    // directed corners
    run_op(0, 24'h000020, 16'hFFF0, 0, 0, 0, 8'h55, 0, 0, 0, 0, "page wrap");
    run_op(11, 24'h0000FF, 0, 0, 0, 16'hFF80, 8'h55, 0, 0, 0, 0, "stack wrap");
    run_op(4, 24'h00FFFF, 0, 16'h0001, 0, 0, 8'h34, 0, 0, 0, 0, "abs no carry");
    run_op(7, 24'hFFFFFF, 0, 16'h0001, 0, 0, 8'h00, 0, 0, 0, 0, "far wrap");
    run_op(7, 24'h12FFF0, 0, 16'h0020, 0, 0, 8'h00, 0, 0, 0, 0, "far carry");
    run_op(1, 24'h000010, 16'h0100, 16'h1234, 0, 0, 0, 1, 0, 0, 0, "R10 narrow index");
    run_op(5, 24'h001000, 0, 0, 16'hABCD, 0, 8'h07, 0, 1, 0, 0, "R10 narrow via emu");
    mem[16] = 8'hFF; mem[17] = 8'hFF; mem[18] = 8'hEE;
    run_op(8, 24'h000010, 0, 0, 16'h0002, 0, 8'h12, 0, 0, 1, 0, "bank carry");
    run_op(9, 24'h000010, 0, 0, 16'h0002, 0, 8'h12, 0, 0, 0, 0, "far ptr carry");
    run_op(13, 24'h000010, 0, 0, 0, 0, 8'h12, 0, 0, 2, 1, "ignore high byte");

    for (int n = 0; n < 600; n++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if ($urandom_range(0, 1) == 0) d[7:0] = 8'h00;
      run_op($urandom_range(0, 14), 24'($urandom), d, 16'($urandom),
             16'($urandom), 16'($urandom), 8'($urandom),
             1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
             $urandom_range(0, 2), ($urandom_range(0, 3) == 0), "random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule